// File: doc/BRIEF.md
# Bus Address Decoder with Keyboard, Speaker and Slot Switches

This block sits on an 8-bit processor bus that carries a 16-bit address, an 8-bit read path and a write flag, with at most one access per clock. It splits the address space by its top nibble into main RAM, an I/O page and ROM. It drives one select line per region and steers the RAM or ROM read data back to the processor. It also returns the block's own read data for I/O locations.

Inside the I/O page the block holds a keyboard latch: a 7-bit character code and a pending-key flag. It also holds a one-bit speaker output that flips on any access to its location, whatever the bus direction or data. For eight expansion slots it decodes per-slot switch pulses and per-slot ROM window selects. Side effects happen on the clock edge that ends the access. Reads see the state from before that edge.

Top module: `iomap_decoder`

## Requirements
- R1: A valid access with bus_addr[15:12] in 0x0..0xB asserts ram_sel alone. A read of such an address returns ram_data on rd_data in the same cycle.
- R2: A valid access with bus_addr[15:12] in 0xD..0xF asserts rom_sel alone. A read of such an address returns rom_data in the same cycle.
- R3: A valid access with bus_addr[15:12] equal to 0xC asserts io_sel alone, and never ram_sel or rom_sel.
- R4: A clock edge with key_strobe high loads key_code into the latch and sets the pending flag. A read of 0xC000 then returns the flag in bit 7 and the code in bits 6:0.
- R5: Any valid access to 0xC010, read or write, clears the pending flag at the end of that cycle. If key_strobe is high in the same cycle, the strobe wins: the flag stays set and the new code is loaded.
- R6: Each valid access to 0xC030, read or write, inverts spkr_out exactly once at the end of that cycle. No other access and no idle cycle changes spkr_out.
- R7: A valid access in 0xC080..0xC0FF raises bit bus_addr[6:4] of slot_dev_sel for that cycle only, and sets slot_reg to bus_addr[3:0]. Otherwise slot_dev_sel is zero and slot_reg is zero.
- R8: A valid access in 0xC100..0xC7FF raises bit bus_addr[10:8] of slot_rom_sel for that cycle. Bit 0 is never raised, and 0xC800..0xCFFF raises no bit.
- R9: A read of any I/O address other than 0xC000 returns 0x00. This includes 0xC010, 0xC030, the slot ranges and 0xC800..0xCFFF.
- R10: A clock edge with rst high clears the key code, the pending flag and spkr_out.
- R11: With bus_valid low, every select and slot output is zero, rd_data is 0x00 and no state changes. A write access also returns 0x00 on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | An access is on the bus this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 16 | Access address |
| ram_data | input | 8 | Read data from main RAM |
| rom_data | input | 8 | Read data from ROM |
| key_code | input | 7 | Character code from the keyboard |
| key_strobe | input | 1 | One-cycle new-key pulse |
| rd_data | output | 8 | Read data returned to the processor |
| ram_sel | output | 1 | Main RAM selected |
| rom_sel | output | 1 | ROM selected |
| io_sel | output | 1 | I/O page selected |
| spkr_out | output | 1 | Speaker level |
| slot_dev_sel | output | 8 | Per-slot switch pulse |
| slot_reg | output | 4 | Switch register index for the pulsed slot |
| slot_rom_sel | output | 8 | Per-slot ROM window select |

## Verification
The flag, the code and the speaker level are the only state. A wrong value in any of them shows at the ports within one cycle: spkr_out is visible directly, and the next read of 0xC000 exposes the flag and code. The bench tracks a reference copy of all three and reads 0xC000 often between side-effect accesses. A missed clear, a double toggle or a lost strobe-versus-clear priority therefore shows on the very next comparison. Decode faults show in the same cycle, as a wrong select, a wrong slot bit or wrong read data.

// File: rtl/iomap_pkg.sv
package iomap_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int KEY_W   = 7;
    localparam int N_SLOTS = 8;
    localparam int SLOT_W  = $clog2(N_SLOTS);
    localparam int REG_W   = 4;

    localparam logic [ADDR_W-1:0] KBD_DATA_ADDR = 16'hC000;
    localparam logic [ADDR_W-1:0] KBD_CLR_ADDR  = 16'hC010;
    localparam logic [ADDR_W-1:0] SPKR_ADDR     = 16'hC030;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_RAM  = 2'd1,
        REG_IO   = 2'd2,
        REG_ROM  = 2'd3
    } region_e;

    typedef struct packed {
        region_e           region;
        logic              kbd_rd;
        logic              kbd_clr;
        logic              spkr_hit;
        logic              slot_sw;
        logic              slot_rom;
        logic [SLOT_W-1:0] sw_idx;
        logic [SLOT_W-1:0] rom_idx;
        logic [REG_W-1:0]  reg_idx;
    } dec_t;

    function automatic region_e region_of(input logic [3:0] nib);
        if (nib <= 4'hB)      return REG_RAM;
        else if (nib == 4'hC) return REG_IO;
        else                  return REG_ROM;
    endfunction

endpackage

// File: rtl/iomap_addr_dec.sv
module iomap_addr_dec
    import iomap_pkg::*;
(
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic io_page;
    logic sw_page;

    always_comb begin
        io_page = valid && (addr[15:12] == 4'hC);
        sw_page = io_page && (addr[11:8] == 4'h0);

        dec          = '0;
        dec.region   = valid ? region_of(addr[15:12]) : REG_NONE;
        dec.kbd_rd   = valid && (addr == KBD_DATA_ADDR);
        dec.kbd_clr  = valid && (addr == KBD_CLR_ADDR);
        dec.spkr_hit = valid && (addr == SPKR_ADDR);
        dec.slot_sw  = sw_page && addr[7];
        dec.slot_rom = io_page && !addr[11] && (addr[10:8] != 3'd0);
        dec.sw_idx   = addr[6:4];
        dec.rom_idx  = addr[10:8];
        dec.reg_idx  = dec.slot_sw ? addr[3:0] : '0;
    end
endmodule

// File: rtl/iomap_kbd.sv
module iomap_kbd
    import iomap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [KEY_W-1:0] code_in,
    input  logic             clr,
    output logic             pending,
    output logic [KEY_W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            code    <= '0;
        end else if (strobe) begin
            pending <= 1'b1;
            code    <= code_in;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    AST_KEY_LOAD: assert property (@(posedge clk) disable iff (rst)
        strobe |=> pending && (code == $past(code_in)));   // R4
    AST_KEY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !strobe) |=> !pending);                     // R5
    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !strobe) |=> $stable(pending) && $stable(code));  // R5
    AST_KEY_RESET: assert property (@(posedge clk)
        rst |=> !pending && (code == '0));                  // R10
endmodule

// File: rtl/iomap_spkr.sv
module iomap_spkr (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst)      level <= 1'b0;
        else if (hit) level <= ~level;
    end

    AST_SPKR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        hit |=> (level != $past(level)));   // R6
    AST_SPKR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(level));           // R6
    AST_SPKR_RESET: assert property (@(posedge clk)
        rst |=> !level);                    // R10
endmodule

// File: rtl/iomap_slot_sel.sv
module iomap_slot_sel
    import iomap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  dec_t               dec,
    output logic [N_SLOTS-1:0] dev_sel,
    output logic [N_SLOTS-1:0] rom_sel
);
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        assign dev_sel[s] = dec.slot_sw  && (dec.sw_idx  == SLOT_W'(s));
        assign rom_sel[s] = dec.slot_rom && (dec.rom_idx == SLOT_W'(s));
    end

    AST_DEVSEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_sel));                     // R7
    AST_SLOTROM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rom_sel) && !rom_sel[0]);      // R8
    AST_SLOT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((|dev_sel) && (|rom_sel)));           // R8
endmodule

// File: rtl/iomap_decoder.sv
module iomap_decoder
    import iomap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  ram_data,
    input  logic [DATA_W-1:0]  rom_data,
    input  logic [KEY_W-1:0]   key_code,
    input  logic               key_strobe,
    output logic [DATA_W-1:0]  rd_data,
    output logic               ram_sel,
    output logic               rom_sel,
    output logic               io_sel,
    output logic               spkr_out,
    output logic [N_SLOTS-1:0] slot_dev_sel,
    output logic [REG_W-1:0]   slot_reg,
    output logic [N_SLOTS-1:0] slot_rom_sel
);
    dec_t             dec;
    logic             key_pending;
    logic [KEY_W-1:0] key_latch;
    logic             is_read;

    iomap_addr_dec u_dec (
        .valid (bus_valid),
        .addr  (bus_addr),
        .dec   (dec)
    );

    iomap_kbd u_kbd (
        .clk     (clk),
        .rst     (rst),
        .strobe  (key_strobe),
        .code_in (key_code),
        .clr     (dec.kbd_clr),
        .pending (key_pending),
        .code    (key_latch)
    );

    iomap_spkr u_spkr (
        .clk   (clk),
        .rst   (rst),
        .hit   (dec.spkr_hit),
        .level (spkr_out)
    );

    iomap_slot_sel u_slot (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .dev_sel (slot_dev_sel),
        .rom_sel (slot_rom_sel)
    );

    assign ram_sel  = (dec.region == REG_RAM);
    assign rom_sel  = (dec.region == REG_ROM);
    assign io_sel   = (dec.region == REG_IO);
    assign slot_reg = dec.reg_idx;
    assign is_read  = bus_valid && !bus_we;

    always_comb begin
        rd_data = '0;
        if (is_read) begin
            unique case (dec.region)
                REG_RAM: rd_data = ram_data;
                REG_ROM: rd_data = rom_data;
                REG_IO:  rd_data = dec.kbd_rd ? {key_pending, key_latch} : '0;
                default: rd_data = '0;
            endcase
        end
    end

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> $onehot({ram_sel, rom_sel, io_sel}));          // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> !(ram_sel || rom_sel || io_sel || (|slot_dev_sel)
                         || (|slot_rom_sel)) && (rd_data == '0));      // R11
    AST_RAM_PASS: assert property (@(posedge clk) disable iff (rst)
        (ram_sel && !bus_we) |-> (rd_data == ram_data));             // R1
    AST_ROM_PASS: assert property (@(posedge clk) disable iff (rst)
        (rom_sel && !bus_we) |-> (rd_data == rom_data));             // R2
    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> (rd_data == '0));                                 // R11
endmodule

// File: tb/iomap_decoder_tb.sv
module iomap_decoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  ram_data;
    logic [7:0]  rom_data;
    logic [6:0]  key_code;
    logic        key_strobe;
    logic [7:0]  rd_data;
    logic        ram_sel, rom_sel, io_sel, spkr_out;
    logic [7:0]  slot_dev_sel;
    logic [3:0]  slot_reg;
    logic [7:0]  slot_rom_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // reference state
    bit       m_flag;
    bit [6:0] m_code;
    bit       m_spkr;

    always #2 clk = ~clk;

    iomap_decoder u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .ram_data(ram_data), .rom_data(rom_data),
        .key_code(key_code), .key_strobe(key_strobe), .rd_data(rd_data),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .io_sel(io_sel),
        .spkr_out(spkr_out), .slot_dev_sel(slot_dev_sel),
        .slot_reg(slot_reg), .slot_rom_sel(slot_rom_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s addr=%h actual=%0h expected=%0h", tag, bus_addr, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    // compare every output against the reference for the current inputs
    task automatic compare();
        int nib = bus_addr[15:12];
        bit v = bus_valid;
        bit rd = v && !bus_we;
        bit e_ram = v && nib <= 11;
        bit e_rom = v && nib >= 13;
        bit e_io  = v && nib == 12;
        bit e_sw  = e_io && bus_addr >= 16'hC080 && bus_addr <= 16'hC0FF;
        bit e_sr  = e_io && bus_addr >= 16'hC100 && bus_addr <= 16'hC7FF;
        logic [7:0] e_dev = e_sw ? (8'd1 << bus_addr[6:4]) : 8'd0;
        logic [7:0] e_srs = e_sr ? (8'd1 << bus_addr[10:8]) : 8'd0;
        logic [3:0] e_reg = e_sw ? bus_addr[3:0] : 4'd0;
        logic [7:0] e_rd;
        string rtag;
        if (!rd)                          begin e_rd = 0;               rtag = "R11"; end
        else if (e_ram)                   begin e_rd = ram_data;        rtag = "R1"; end
        else if (e_rom)                   begin e_rd = rom_data;        rtag = "R2"; end
        else if (bus_addr == 16'hC000)    begin e_rd = {m_flag, m_code}; rtag = "R4 R5"; end
        else                              begin e_rd = 0;               rtag = "R9"; end
        check(rd_data == e_rd, rtag, rd_data, e_rd);
        check(ram_sel == e_ram, "R1 ram_sel", ram_sel, e_ram);
        check(rom_sel == e_rom, "R2 rom_sel", rom_sel, e_rom);
        check(io_sel == e_io, "R3 io_sel", io_sel, e_io);
        check(slot_dev_sel == e_dev, "R7 slot_dev_sel", slot_dev_sel, e_dev);
        check(slot_reg == e_reg, "R7 slot_reg", slot_reg, e_reg);
        check(slot_rom_sel == e_srs, "R8 slot_rom_sel", slot_rom_sel, e_srs);
        check(spkr_out == m_spkr, "R6 spkr_out", spkr_out, m_spkr);
    endtask

    // one bus cycle: drive at falling edge, compare, then advance model at rising edge
    task automatic cyc(input bit v, input bit we, input logic [15:0] a,
                       input bit ks = 0, input logic [6:0] kc = 0);
        @(negedge clk);
        bus_valid = v; bus_we = we; bus_addr = a;
        ram_data = a[7:0] ^ 8'h5A; rom_data = ~a[7:0] ^ a[15:8];
        key_strobe = ks; key_code = kc;
        #1 compare();
        @(posedge clk);
        if (ks) begin m_flag = 1; m_code = kc; end
        else if (v && a == 16'hC010) m_flag = 0;
        if (v && a == 16'hC030) m_spkr = ~m_spkr;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; bus_valid = 0; key_strobe = 0;
        @(posedge clk); @(posedge clk);
        m_flag = 0; m_code = 0; m_spkr = 0;
        @(negedge clk); rst = 0;
        #1;
        check(spkr_out == 0, "R10 spkr after reset", spkr_out, 0);
    endtask

    task automatic read_kbd(input logic [7:0] exp, input string tag);
        cyc(1, 0, 16'hC000);
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    initial begin
        rst = 1; bus_valid = 0; bus_we = 0; bus_addr = 0;
        ram_data = 0; rom_data = 0; key_code = 0; key_strobe = 0;
        m_flag = 0; m_code = 0; m_spkr = 0;
        do_reset();
        read_kbd(8'h00, "R10 key latch after reset");

        // R1 RAM region, reads and a write
        cyc(1, 0, 16'h0000); cyc(1, 0, 16'h5A5A); cyc(1, 0, 16'hBFFF);
        cyc(1, 1, 16'h1234);
        // R2 ROM region
        cyc(1, 0, 16'hD000); cyc(1, 0, 16'hE123); cyc(1, 0, 16'hFFFF);
        // R11 idle cycles, including on side-effect addresses
        cyc(0, 0, 16'hC030); cyc(0, 1, 16'hC010); cyc(0, 0, 16'hC0A3);

        // R4 key load
        cyc(0, 0, 16'h0000, 1, 7'h41);
        read_kbd(8'hC1, "R4 key read");
        cyc(0, 0, 16'h0000, 1, 7'h7F);
        read_kbd(8'hFF, "R4 key overwrite");
        // R5 clear by read, then by write
        cyc(1, 0, 16'hC010);
        read_kbd(8'h7F, "R5 clear by read");
        cyc(0, 0, 16'h0000, 1, 7'h20);
        cyc(1, 1, 16'hC010);
        read_kbd(8'h20, "R5 clear by write");
        // R5 strobe wins over clear
        cyc(1, 0, 16'hC010, 1, 7'h33);
        read_kbd(8'hB3, "R5 strobe beats clear");
        cyc(1, 0, 16'hC011);
        read_kbd(8'hB3, "R5 neighbour address does not clear");

        // R6 speaker
        cyc(1, 0, 16'hC030); cyc(1, 1, 16'hC030); cyc(1, 0, 16'hC030);
        cyc(1, 0, 16'hC031); cyc(1, 0, 16'hC020);
        cyc(0, 0, 16'hC030);

        // R7 slot switches
        for (int s = 0; s < 8; s++)
            for (int r = 0; r < 16; r += 5)
                cyc(1, s[0], 16'hC080 + 16'(s * 16 + r));
        cyc(1, 0, 16'hC07F); cyc(1, 0, 16'hC0FF);
        // R8 slot ROM windows and the area beyond
        for (int s = 1; s < 8; s++) begin
            cyc(1, 0, 16'hC000 + 16'(s * 256));
            cyc(1, 0, 16'hC0FF + 16'(s * 256));
        end
        cyc(1, 0, 16'hC800); cyc(1, 0, 16'hCFFF);
        // R9 unused I/O reads
        cyc(1, 0, 16'hC00F); cyc(1, 0, 16'hC050); cyc(1, 0, 16'hCABC);

        // R10 reset clears live state
        cyc(0, 0, 16'h0000, 1, 7'h55);
        cyc(1, 0, 16'hC030);
        do_reset();
        read_kbd(8'h00, "R10 latch cleared by reset");

        finish_run();
    end
endmodule